// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block supplies the address for a four-beat memory burst. A full-width starting address is taken from the address bus when one of two load strobes is raised: one driven by the processor, the other by an external controller. After that, every cycle with the advance input high moves the burst one beat forward. Only the two lowest address bits change, and they wrap after the fourth beat. The upper bits keep the captured value for the whole burst.

A static mode input picks one of two beat orders. In interleaved order the low bits are the captured start bits XOR a 2-bit beat count. In linear order they are the start bits plus the beat count, modulo 4. A small state machine records who owns the burst. Its states are `ST_IDLE` (no burst since reset), `ST_PROC` (loaded by the processor strobe) and `ST_CTRL` (loaded by the controller strobe). Its transitions are:

- `IDLE→PROC`, `CTRL→PROC` and `PROC→PROC` on the processor strobe.
- `IDLE→CTRL`, `PROC→CTRL` and `CTRL→CTRL` on the controller strobe when the processor strobe is low.
- Any state to itself (hold) when no strobe is present.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr_out` is 0 and both `burst_proc` and `burst_ctrl` are 0 (state `ST_IDLE`).
- R2: When a strobe is high at a clock edge, from the next cycle on `addr_out` equals the `addr_in` value sampled at that edge. This makes the beat count 0.
- R3: If both strobes are high at the same edge, the processor strobe wins: `burst_proc`=1 and `burst_ctrl`=0 afterwards. A controller strobe alone gives `burst_ctrl`=1 and `burst_proc`=0. The two flags are never both 1.
- R4: A strobe reloads the address even when `step` is high in the same cycle. The advance is discarded.
- R5: Each edge with `step` high, no strobe and a burst owned adds one to the 2-bit beat count. After four such steps the low bits return to the start value.
- R6: With `lin_mode`=0, `addr_out[1:0]` equals start bits XOR beat count.
- R7: With `lin_mode`=1, `addr_out[1:0]` equals (start bits + beat count) mod 4.
- R8: `addr_out[15:2]` keeps the captured value while no strobe arrives.
- R9: With no strobe and `step` low, `addr_out` holds its value.
- R10: In `ST_IDLE`, `step` without a strobe has no effect: `addr_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | 16 | Starting address bus |
| strb_proc | input | 1 | Processor load strobe (higher priority) |
| strb_ctrl | input | 1 | Controller load strobe |
| step | input | 1 | Advance burst by one beat |
| lin_mode | input | 1 | Static order select: 0 interleaved, 1 linear |
| addr_out | output | 16 | Current burst address |
| burst_proc | output | 1 | Burst owned by processor strobe |
| burst_ctrl | output | 1 | Burst owned by controller strobe |

## Verification
The output address is a direct function of the registers, so any error shows up one cycle after the edge that caused it:

- A wrong beat count gives a wrong low pair on the next sampled cycle.
- A wrong captured start bit or upper bit is visible in the first cycle after the load.
- A wrong owner state shows on the flag outputs, or as an advance that should have been ignored in idle.

The bench sweeps every start pair, both orders, both strobe sources and full wraps interleaved with holds, so every beat value of every order is compared.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int ADDR_W  = 16;
    localparam int BEAT_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROC = 2'd1,
        ST_CTRL = 2'd2
    } bag_state_e;
endpackage

// File: rtl/bag_owner_fsm.sv
module bag_owner_fsm
    import bag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strb_proc,
    input  logic       strb_ctrl,
    input  logic       step,
    output logic       load,
    output logic       advance,
    output bag_state_e state
);
    bag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PROC, ST_CTRL: begin
                if (strb_proc)      state_d = ST_PROC;
                else if (strb_ctrl) state_d = ST_CTRL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = strb_proc | strb_ctrl;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE:          advance = 1'b0;
            ST_PROC, ST_CTRL: advance = step & ~load;
            default:          advance = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    output logic [CW-1:0] beat
);
    logic [CW-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (load)    beat_q <= '0;
        else if (advance) beat_q <= beat_q + 1'b1;
    end

    assign beat = beat_q;
endmodule

// File: rtl/bag_start_reg.sv
module bag_start_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] start
);
    logic [AW-1:0] start_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    start_q <= '0;
        else if (load) start_q <= addr_in;
    end

    assign start = start_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = BEAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          strb_proc,
    input  logic          strb_ctrl,
    input  logic          step,
    input  logic          lin_mode,
    output logic [AW-1:0] addr_out,
    output logic          burst_proc,
    output logic          burst_ctrl
);
    localparam int HW = AW - CW;

    logic          load;
    logic          advance;
    bag_state_e    state;
    logic [CW-1:0] beat;
    logic [AW-1:0] start;
    logic [CW-1:0] low_bits;

    bag_owner_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_proc (strb_proc),
        .strb_ctrl (strb_ctrl),
        .step      (step),
        .load      (load),
        .advance   (advance),
        .state     (state)
    );

    bag_beat_cnt #(.CW(CW)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .beat    (beat)
    );

    bag_start_reg #(.AW(AW)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .start   (start)
    );

    always_comb begin
        if (lin_mode) low_bits = start[CW-1:0] + beat;
        else          low_bits = start[CW-1:0] ^ beat;
    end

    if (HW > 0) begin : g_upper
        assign addr_out = {start[AW-1:CW], low_bits};
    end else begin : g_noupper
        assign addr_out = low_bits;
    end

    always_comb begin
        burst_proc = 1'b0;
        burst_ctrl = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PROC: burst_proc = 1'b1;
            ST_CTRL: burst_ctrl = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 16,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          strb_proc,
    input logic          strb_ctrl,
    input logic          step,
    input logic          lin_mode,
    input logic [AW-1:0] addr_out,
    input logic          burst_proc,
    input logic          burst_ctrl
);
    logic any_strb;
    logic ready;
    assign any_strb = strb_proc | strb_ctrl;

    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= 1'b1;
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_strb |=> addr_out == $past(addr_in));

    // R3
    proc_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_proc |=> burst_proc && !burst_ctrl);

    // R3
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $onehot0({burst_proc, burst_ctrl}));

    // R8
    upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !any_strb) |=> $stable(addr_out[AW-1:CW]));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !any_strb && !step) |=> $stable(addr_out));

    // R10
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !any_strb && !burst_proc && !burst_ctrl) |=> addr_out == '0);

    // R7
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !any_strb && step && lin_mode && (burst_proc || burst_ctrl))
        |=> (!lin_mode || addr_out[CW-1:0] == CW'($past(addr_out[CW-1:0]) + 1'b1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .strb_proc  (strb_proc),
    .strb_ctrl  (strb_ctrl),
    .step       (step),
    .lin_mode   (lin_mode),
    .addr_out   (addr_out),
    .burst_proc (burst_proc),
    .burst_ctrl (burst_ctrl)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_in = '0;
    logic        strb_proc = 1'b0;
    logic        strb_ctrl = 1'b0;
    logic        step = 1'b0;
    logic        lin_mode = 1'b0;
    logic [15:0] addr_out;
    logic        burst_proc;
    logic        burst_ctrl;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [15:0] m_start = '0;
    int          m_beat = 0;
    int          m_own = 0; // 0 idle, 1 proc, 2 ctrl

    always #5 clk = ~clk;

    burst_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strb_proc(strb_proc), .strb_ctrl(strb_ctrl), .step(step),
        .lin_mode(lin_mode), .addr_out(addr_out),
        .burst_proc(burst_proc), .burst_ctrl(burst_ctrl)
    );

    function automatic logic [15:0] exp_addr();
        logic [1:0] lo;
        if (lin_mode) lo = m_start[1:0] + 2'(m_beat);
        else          lo = m_start[1:0] ^ 2'(m_beat);
        return {m_start[15:2], lo};
    endfunction

    task automatic check(string tag, logic [15:0] exp_a, int exp_own);
        n_cmp++;
        if (addr_out !== exp_a || burst_proc !== (exp_own == 1) || burst_ctrl !== (exp_own == 2)) begin
            n_bad++;
            $display("FAIL %s: addr=%h own=%b%b expected addr=%h own=%0d",
                     tag, addr_out, burst_proc, burst_ctrl, exp_a, exp_own);
        end
    endtask

    // drive one cycle, update model, check after the edge
    task automatic cyc(logic p, logic c, logic a, logic [15:0] ad, string tag);
        strb_proc = p; strb_ctrl = c; step = a; addr_in = ad;
        @(posedge clk);
        if (p || c) begin
            m_start = ad; m_beat = 0; m_own = p ? 1 : 2;
        end else if (a && m_own != 0) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        strb_proc = 1'b0; strb_ctrl = 1'b0; step = 1'b0;
        check(tag, exp_addr(), m_own);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", 16'h0000, 0);
        // R10 advance while idle is ignored
        cyc(1'b0, 1'b0, 1'b1, 16'h1234, "R10");
        cyc(1'b0, 1'b0, 1'b1, 16'hFFFF, "R10");

        for (int m = 0; m < 2; m++) begin
            lin_mode = m[0];
            for (int s = 0; s < 4; s++) begin
                for (int src = 0; src < 2; src++) begin
                    logic [15:0] base;
                    base = 16'(((s * 7 + m * 13 + src * 29) * 1021) & 16'hFFFC) | 16'(s);
                    cyc(src == 0, src == 1, 1'b0, base, src == 0 ? "R2" : "R3");
                    for (int b = 1; b < 4; b++) begin
                        cyc(1'b0, 1'b0, 1'b1, 16'hDEAD, m ? "R7" : "R6");
                        cyc(1'b0, 1'b0, 1'b0, 16'hBEEF, "R9");
                    end
                    // fourth step wraps to start
                    cyc(1'b0, 1'b0, 1'b1, 16'h0F0F, "R5");
                    n_cmp++;
                    if (addr_out !== base) begin
                        n_bad++;
                        $display("FAIL R5: wrap addr=%h expected %h", addr_out, base);
                    end
                    n_cmp++;
                    if (addr_out[15:2] !== base[15:2]) begin
                        n_bad++;
                        $display("FAIL R8: upper=%h expected %h", addr_out[15:2], base[15:2]);
                    end
                end
            end
        end

        // R3 both strobes: processor wins
        lin_mode = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 16'hA5A6, "R3");
        cyc(1'b1, 1'b1, 1'b0, 16'h5A59, "R3");
        cyc(1'b0, 1'b0, 1'b1, 16'h0000, "R6");
        // R4 strobe with step: reload, beat 0
        cyc(1'b0, 1'b1, 1'b1, 16'hC3C2, "R4");
        cyc(1'b1, 1'b0, 1'b1, 16'h7771, "R4");
        lin_mode = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 16'h0000, "R7");
        cyc(1'b0, 1'b0, 1'b1, 16'h0000, "R7");
        cyc(1'b0, 1'b0, 1'b0, 16'h0000, "R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule